// File: doc/BRIEF.md
# Clear-on-Read Interrupt Controller

This block gathers single-cycle event pulses from the FIFO and error logic of a network MAC and holds each one in a sticky source bit. A software-writable mask register selects which latched causes may raise the interrupt. A master bit in that same register gates the single level-sensitive `irq` output. Reading the source register returns every latched cause and empties the register in that same access. Software therefore never writes ones to acknowledge.

A typical driver works in three steps. It first reads the source register once to throw away stale events. It then writes the mask with the master bit set. While it services a cause, it can clear that cause's mask bit, for example while draining received packets, and set it again afterwards. The interrupt line follows the mask without delay.

Access decoding is handled by a small state machine whose state records the kind of access taken on the previous edge. Its states are ST_IDLE (no access), ST_RD_SRC (source read, data being returned), ST_RD_MASK (mask read), ST_RD_NONE (read of an unused address), ST_WR_MASK (mask written) and ST_WR_IGN (write that is dropped). Every state can move to every other state. On each edge the transition is chosen only from the request present in that cycle: no request leads to ST_IDLE, a read leads to the read state for its address, and a write leads to ST_WR_MASK or ST_WR_IGN.

Cause bit map, used by both the source and the mask registers:
- bit 0: transmit data FIFO almost empty
- bit 1: transmit FIFO full
- bit 2: transmit frame discarded
- bit 3: receive command FIFO almost full
- bit 4: receive command FIFO full
- bit 5: receive data FIFO full
- bit 6: receive error
- bit 7: receive packet ready

Top module: `irq_cor_ctrl`

## Requirements
- R1: After reset the source bits, mask bits and master bit are all 0, `irq` is 0 and `rd_valid` is 0.
- R2: A 1 on `evt_i[k]` in any cycle sets source bit k at the next edge. The bit stays set until a source read, whatever the mask holds. The cause bit map is listed above.
- R3: A read of address 0 (source) returns the source bits as they stood before that access, in `rd_data[7:0]` with upper bits 0, and clears them at the same edge.
- R4: An event that arrives in the cycle of a clearing source read is still latched afterwards and shows up in the next source read.
- R5: Address 1 (mask) holds per-cause enables in bits 7:0 and the master enable in bit 15. It reads back those bits, and bits 14:8 read 0.
- R6: `irq` is 1 exactly when the master bit is 1 and some source bit is set whose mask bit is 1. It changes right after the edge that updates the registers, so clearing a mask bit or the master bit drops `irq` with no extra cycle.
- R7: A write to address 0, 2 or 3 changes nothing, and a read of address 2 or 3 returns 0.
- R8: `rd_valid` is 1 in the cycle after each read request and 0 otherwise. `rd_data` is 0 whenever `rd_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 8 | Event pulses, one per cause |
| acc_valid | input | 1 | Register access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 2 | Register address (0 source, 1 mask) |
| acc_wdata | input | 16 | Write data |
| rd_valid | output | 1 | Read data valid (one cycle after a read) |
| rd_data | output | 16 | Read data |
| irq | output | 1 | Level interrupt request |

## Verification
A source bit that is lost or stuck appears at the ports only through the next source read, or through `irq` once that cause is enabled. The random mix therefore reads the source register often, so such an error is caught within a few cycles. A wrong mask or master value shows up on `irq` in the cycle right after the write. The cases where an event coincides with the clearing read show up on the following read.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int ADDR_SRC  = 0;
    localparam int ADDR_MASK = 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_SRC,
        ST_RD_MASK,
        ST_RD_NONE,
        ST_WR_MASK,
        ST_WR_IGN
    } acc_state_e;
endpackage

// File: rtl/irqc_src_bank.sv
module irqc_src_bank #(
    parameter int NSRC = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt,
    input  logic            clr,
    output logic [NSRC-1:0] src_q
);
    for (genvar k = 0; k < NSRC; k++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)
                src_q[k] <= 1'b0;
            else if (clr)
                src_q[k] <= evt[k];
            else
                src_q[k] <= src_q[k] | evt[k];
        end
    end
endmodule

// File: rtl/irqc_mask_reg.sv
module irqc_mask_reg #(
    parameter int NSRC   = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [NSRC-1:0]   en_q,
    output logic              gen_q
);
    localparam int GEN_BIT = DATA_W - 1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            gen_q <= 1'b0;
        end else if (wr) begin
            en_q  <= wdata[NSRC-1:0];
            gen_q <= wdata[GEN_BIT];
        end
    end
endmodule

// File: rtl/irqc_port_fsm.sv
module irqc_port_fsm
    import irqc_pkg::*;
#(
    parameter int NSRC   = 8,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [NSRC-1:0]   src_q,
    input  logic [NSRC-1:0]   en_q,
    input  logic              gen_q,
    output logic              clr_src,
    output logic              wr_mask,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    localparam int GEN_BIT = DATA_W - 1;

    acc_state_e        state_q, state_d;
    logic [DATA_W-1:0] hold_q, hold_d;
    logic [DATA_W-1:0] mask_word;

    always_comb begin
        mask_word              = '0;
        mask_word[NSRC-1:0]    = en_q;
        mask_word[GEN_BIT]     = gen_q;
    end

    // next-state decode from the request in this cycle
    always_comb begin
        if (!acc_valid)
            state_d = ST_IDLE;
        else if (acc_write)
            state_d = (acc_addr == ADDR_W'(ADDR_MASK)) ? ST_WR_MASK : ST_WR_IGN;
        else if (acc_addr == ADDR_W'(ADDR_SRC))
            state_d = ST_RD_SRC;
        else if (acc_addr == ADDR_W'(ADDR_MASK))
            state_d = ST_RD_MASK;
        else
            state_d = ST_RD_NONE;
    end

    always_comb begin
        hold_d = '0;
        unique case (state_d)
            ST_RD_SRC:  hold_d[NSRC-1:0] = src_q;
            ST_RD_MASK: hold_d = mask_word;
            ST_IDLE, ST_RD_NONE, ST_WR_MASK, ST_WR_IGN: hold_d = '0;
            default:    hold_d = '0;
        endcase
    end

    assign clr_src = (state_d == ST_RD_SRC);
    assign wr_mask = (state_d == ST_WR_MASK);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            hold_q  <= hold_d;
        end
    end

    always_comb begin
        rd_valid = 1'b0;
        rd_data  = '0;
        unique case (state_q)
            ST_RD_SRC, ST_RD_MASK, ST_RD_NONE: begin
                rd_valid = 1'b1;
                rd_data  = hold_q;
            end
            ST_IDLE, ST_WR_MASK, ST_WR_IGN: begin
                rd_valid = 1'b0;
                rd_data  = '0;
            end
            default: begin
                rd_valid = 1'b0;
                rd_data  = '0;
            end
        endcase
    end
endmodule

// File: rtl/irq_cor_ctrl.sv
module irq_cor_ctrl #(
    parameter int NSRC   = 8,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   evt_i,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    logic [NSRC-1:0] src_q;
    logic [NSRC-1:0] en_q;
    logic            gen_q;
    logic            clr_src;
    logic            wr_mask;

    irqc_src_bank #(.NSRC(NSRC)) u_src (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (evt_i),
        .clr   (clr_src),
        .src_q (src_q)
    );

    irqc_mask_reg #(.NSRC(NSRC), .DATA_W(DATA_W)) u_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr_mask),
        .wdata (acc_wdata),
        .en_q  (en_q),
        .gen_q (gen_q)
    );

    irqc_port_fsm #(.NSRC(NSRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_addr  (acc_addr),
        .src_q     (src_q),
        .en_q      (en_q),
        .gen_q     (gen_q),
        .clr_src   (clr_src),
        .wr_mask   (wr_mask),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    assign irq = gen_q & (|(src_q & en_q));
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
    parameter int NSRC   = 8,
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NSRC-1:0]   evt_i,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              wr_gen,
    input logic [NSRC-1:0]   src_q,
    input logic              rd_valid,
    input logic              irq
);
    logic rd_src;
    assign rd_src = acc_valid && !acc_write && (acc_addr == ADDR_W'(0));

    // R2: latched causes persist unless a source read occurs
    a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_src |=> ((src_q & $past(src_q)) == $past(src_q)));

    // R3: a source read leaves only the events of that cycle
    a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
        rd_src |=> (src_q == $past(evt_i)));

    // R4: no event is ever dropped
    a_r4_keep: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((src_q & $past(evt_i)) == $past(evt_i)));

    // R6: clearing the master bit silences the interrupt at once
    a_r6_gen_off: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && acc_addr == ADDR_W'(1) && !wr_gen) |=> !irq);

    // R8: read response timing
    a_r8_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write) |=> rd_valid);
    a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && !acc_write) |=> !rd_valid);
endmodule

bind irq_cor_ctrl irqc_checker #(.NSRC(NSRC), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_i     (evt_i),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_addr  (acc_addr),
    .wr_gen    (acc_wdata[DATA_W-1]),
    .src_q     (src_q),
    .rd_valid  (rd_valid),
    .irq       (irq)
);

// File: tb/test_irq_cor_ctrl.sv
module test_irq_cor_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  evt_i = '0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [1:0]  acc_addr = '0;
    logic [15:0] acc_wdata = '0;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic        irq;

    always #10 clk = ~clk;

    irq_cor_ctrl i_irq_cor_ctrl (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i),
        .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .irq(irq)
    );

    int total = 0;
    int bad = 0;
    logic [7:0] m_src = '0;
    logic [7:0] m_en = '0;
    logic       m_gen = 1'b0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_read(logic [1:0] a);
        case (a)
            2'd0:    return {8'h00, m_src};
            2'd1:    return {m_gen, 7'h00, m_en};
            default: return 16'h0000;
        endcase
    endfunction

    function automatic string rd_tag(logic [1:0] a);
        case (a)
            2'd0:    return "R3 source read";
            2'd1:    return "R5 mask read";
            default: return "R7 unused read";
        endcase
    endfunction

    function automatic logic exp_irq();
        return m_gen & (|(m_src & m_en));
    endfunction

    // one access cycle; called at a falling edge
    task automatic cyc(logic v, logic w, logic [1:0] a, logic [15:0] d, logic [7:0] e);
        logic        ev;
        logic [15:0] ed;
        acc_valid = v; acc_write = w; acc_addr = a; acc_wdata = d; evt_i = e;
        ev = v && !w;
        ed = ev ? exp_read(a) : 16'h0000;
        if (v && !w && a == 2'd0) m_src = e;
        else                      m_src = m_src | e;
        if (v && w && a == 2'd1) begin
            m_en = d[7:0];
            m_gen = d[15];
        end
        @(posedge clk);
        @(negedge clk);
        chk("R8 rd_valid", {31'd0, rd_valid}, {31'd0, ev});
        chk(ev ? rd_tag(a) : "R8 rd_data idle", {16'd0, rd_data}, {16'd0, ed});
        chk("R6 irq", {31'd0, irq}, {31'd0, exp_irq()});
    endtask

    initial begin
        #(20 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        chk("R1 irq in reset", {31'd0, irq}, 32'd0);
        chk("R1 rd_valid in reset", {31'd0, rd_valid}, 32'd0);
        rst_n = 1'b1;
        // R1: registers empty after reset
        cyc(1, 0, 2'd0, 16'h0, 8'h00);
        cyc(1, 0, 2'd1, 16'h0, 8'h00);
        // R2: event latched with mask cleared, no irq
        cyc(0, 0, 2'd0, 16'h0, 8'h08);
        cyc(0, 0, 2'd0, 16'h0, 8'h00);
        cyc(1, 0, 2'd0, 16'h0, 8'h00);
        // R4: events arriving with the clearing read survive
        cyc(0, 0, 2'd0, 16'h0, 8'h24);
        cyc(1, 0, 2'd0, 16'h0, 8'h81);
        cyc(1, 0, 2'd0, 16'h0, 8'h00);
        // R6: enable cause 3 with master, then drop cause 3 enable
        cyc(1, 1, 2'd1, 16'h8008, 8'h08);
        cyc(1, 1, 2'd1, 16'h8001, 8'h00);
        cyc(1, 1, 2'd1, 16'h8008, 8'h00);
        cyc(1, 1, 2'd1, 16'h0008, 8'h00);
        // R7: writes to source and unused addresses ignored
        cyc(1, 1, 2'd0, 16'hFFFF, 8'h00);
        cyc(1, 1, 2'd2, 16'hFFFF, 8'h00);
        cyc(1, 1, 2'd3, 16'hFFFF, 8'h00);
        cyc(1, 0, 2'd2, 16'h0, 8'h00);
        cyc(1, 0, 2'd3, 16'h0, 8'h00);
        cyc(1, 0, 2'd0, 16'h0, 8'h00);
        // R5: unused mask bits read zero
        cyc(1, 1, 2'd1, 16'hFFFF, 8'h00);
        cyc(1, 0, 2'd1, 16'h0, 8'h00);
        // random mix
        for (int i = 0; i < 800; i++) begin
            logic [31:0] r;
            r = $urandom;
            cyc(r[0] | r[1], r[2] & r[3], r[5:4], $urandom,
                8'($urandom & $urandom & $urandom));
        end
        acc_valid = 1'b0;
        evt_i = '0;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule